// File: doc/BRIEF.md
# Buck Phase Gate Sequencer

This block turns a decoded PWM command into the two gate enables of one synchronous buck phase: the high-side switch and the low-side switch. The PWM command arrives already sorted into three levels (low, high, mid-level). A mid level that lasts for a programmable hold-off parks the phase with both switches off. Every gate turn-on waits for two things: the opposite gate must report itself discharged, and a fixed dead-time count must then run out. Every PWM-driven turn-off is delayed by its own count.

Four conditions override the PWM command. An active-low run input, low, turns both gates off. A supply-good flag, when it drops, does the same. An active-low skip request blanks only the low side, so that the phase runs in diode-emulation mode. If a discharge flag never arrives, a watchdog holds both gates off and raises a sticky fault. Only the run input clears that fault. All delays are counted in clock cycles. With the default 1 ns clock, the parameters give 150 ns of hold-off, 10 ns of dead time and 20 ns of turn-off delay.

Top module: `buck_gate_seq`

## Requirements
- R1: After the delays have elapsed, with run high, supply good and skip inactive (skip_n high), pwm_lvl 2'b01 (high) gives hs_gate=1 and ls_gate=0, and pwm_lvl 2'b00 (low) gives hs_gate=0 and ls_gate=1.
- R2: A PWM change drops the conducting gate exactly OFF_CYC+1 clock edges after the new level is first sampled. The opposite gate rises DEAD_CYC edges after the first edge at which the discharge flag of the dropped gate is sampled high.
- R3: hs_gate and ls_gate are never high in the same cycle. A gate rises only if, at the edge before, the opposite gate was low and its discharge flag was high.
- R4: When skip_n is low, ls_gate is low from the next clock edge on. hs_gate still follows pwm_lvl 2'b01, and pwm_lvl 2'b00 then gives both gates low. The skip blanking wins over a dead-time count that completes on the same edge.
- R5: When run is low, both gates are low from the next clock edge on, whatever pwm_lvl and skip_n are.
- R6: When supply_ok is low, both gates are low from the next clock edge on, whatever pwm_lvl is.
- R7: A mid level on pwm_lvl (2'b10 or 2'b11) held for HOLD_CYC sampled edges turns both gates off. The conducting gate falls at edge HOLD_CYC+OFF_CYC. A mid level that lasts fewer edges leaves the gates as they were. This holds for either level of skip_n.
- R8: If a gate waits for the opposite discharge flag for TMO_CYC consecutive cycles, fb_fault rises and both gates stay low. fb_fault stays high while run is high and clears on the edge after run is sampled low.
- R9: Out of reset, hs_gate, ls_gate and fb_fault are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 10/11 mid |
| run | input | 1 | Active-low disable; low forces both gates off |
| skip_n | input | 1 | Active-low skip request; low blanks the low side |
| supply_ok | input | 1 | Undervoltage flag; low clamps both gates |
| hs_off_fb | input | 1 | High-side gate reported discharged |
| ls_off_fb | input | 1 | Low-side gate reported discharged |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| fb_fault | output | 1 | Sticky discharge-timeout fault |

## Verification
The low-side dead-time count can finish on the same edge at which skip blanking arrives. The bench provokes this by counting edges from a high-to-low PWM step through the turn-off delay, the one-cycle discharge feedback and the dead time. It then lowers skip_n just before the edge at which ls_gate would rise, and judges that ls_gate never goes high. In the same way, the hold-off expiry is timed against the turn-off count, and the edge on which the gate falls is checked exactly.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {
    PWM_LO  = 2'b00,
    PWM_HI  = 2'b01,
    PWM_MID = 2'b10,
    PWM_MDX = 2'b11
  } pwm_lvl_e;

  typedef enum logic [1:0] {
    TGT_OFF = 2'b00,
    TGT_HS  = 2'b01,
    TGT_LS  = 2'b10
  } tgt_e;

  localparam int LEG_HS = 0;
  localparam int LEG_LS = 1;
  localparam int NLEG   = 2;
endpackage

// File: rtl/bgs_holdoff.sv
module bgs_holdoff
  import bgs_pkg::*;
#(
  parameter int HOLD_CYC = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  output tgt_e       tgt
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  tgt_e          tgt_q, tgt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    case (pwm_lvl_e'(pwm_lvl))
      PWM_HI: begin
        tgt_d = TGT_HS;
        cnt_d = '0;
      end
      PWM_LO: begin
        tgt_d = TGT_LS;
        cnt_d = '0;
      end
      default: begin
        if (cnt_q == CW'(HOLD_CYC - 1)) tgt_d = TGT_OFF;
        else                            cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_OFF;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  assign tgt = tgt_q;
endmodule

// File: rtl/bgs_leg.sv
module bgs_leg #(
  parameter int DEAD_CYC = 10,
  parameter int OFF_CYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic kill,
  input  logic opp_gate,
  input  logic opp_off,
  output logic gate,
  output logic stalled
);
  localparam int MAXC = (DEAD_CYC > OFF_CYC) ? DEAD_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          gate_q, gate_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          may_rise;

  assign may_rise = want && !opp_gate && opp_off;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (kill) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (gate_q) begin
      if (want) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(OFF_CYC - 1)) begin
        gate_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (may_rise) begin
      if (cnt_q == CW'(DEAD_CYC - 1)) begin
        gate_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate    = gate_q;
  assign stalled = want && !kill && !gate_q && !opp_gate && !opp_off;
endmodule

// File: rtl/bgs_fbwatch.sv
module bgs_fbwatch #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stalled,
  output logic fault
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic          flt_q, flt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    flt_d = flt_q;
    cnt_d = cnt_q;
    if (!run) begin
      flt_d = 1'b0;
      cnt_d = '0;
    end else if (!flt_q) begin
      if (!stalled)                          cnt_d = '0;
      else if (cnt_q == CW'(TMO_CYC - 1))    flt_d = 1'b1;
      else                                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign fault = flt_q;
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import bgs_pkg::*;
#(
  parameter int HOLD_CYC = 150,
  parameter int DEAD_CYC = 10,
  parameter int OFF_CYC  = 20,
  parameter int TMO_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       run,
  input  logic       skip_n,
  input  logic       supply_ok,
  input  logic       hs_off_fb,
  input  logic       ls_off_fb,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic       fb_fault
);
  tgt_e            tgt;
  logic            kill_all;
  logic [NLEG-1:0] want, kill, gate, off_fb, stalled;

  bgs_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_lvl (pwm_lvl),
    .tgt     (tgt)
  );

  assign kill_all     = !run || !supply_ok || fb_fault;
  assign want[LEG_HS] = (tgt == TGT_HS);
  assign want[LEG_LS] = (tgt == TGT_LS);
  assign kill[LEG_HS] = kill_all;
  assign kill[LEG_LS] = kill_all || !skip_n;
  assign off_fb[LEG_HS] = hs_off_fb;
  assign off_fb[LEG_LS] = ls_off_fb;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    bgs_leg #(.DEAD_CYC(DEAD_CYC), .OFF_CYC(OFF_CYC)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want[g]),
      .kill     (kill[g]),
      .opp_gate (gate[NLEG-1-g]),
      .opp_off  (off_fb[NLEG-1-g]),
      .gate     (gate[g]),
      .stalled  (stalled[g])
    );
  end

  bgs_fbwatch #(.TMO_CYC(TMO_CYC)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .stalled (|stalled),
    .fault   (fb_fault)
  );

  assign hs_gate = gate[LEG_HS];
  assign ls_gate = gate[LEG_LS];
endmodule

// File: rtl/bgs_chk.sv
module bgs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwm_lvl,
  input logic       run,
  input logic       skip_n,
  input logic       supply_ok,
  input logic       hs_off_fb,
  input logic       ls_off_fb,
  input logic       hs_gate,
  input logic       ls_gate,
  input logic       fb_fault
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R3
  hs_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ($past(ls_off_fb) && !$past(ls_gate)));

  // R3
  ls_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> ($past(hs_off_fb) && !$past(hs_gate)));

  // R4
  skip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_n |=> !ls_gate);

  // R5
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!hs_gate && !ls_gate));

  // R6
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!hs_gate && !ls_gate));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_fault && run) |=> fb_fault);

  // R8
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !fb_fault);

  // R8
  fault_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_fault |=> (!hs_gate && !ls_gate));
endmodule

bind buck_gate_seq bgs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_lvl   (pwm_lvl),
  .run       (run),
  .skip_n    (skip_n),
  .supply_ok (supply_ok),
  .hs_off_fb (hs_off_fb),
  .ls_off_fb (ls_off_fb),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate),
  .fb_fault  (fb_fault)
);

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam realtime CLK_PERIOD = 1.0;
  localparam int HOLD = 150;
  localparam int DEAD = 10;
  localparam int OFFC = 20;
  localparam int TMO  = 64;
  localparam int SETTLE = HOLD + OFFC + DEAD + 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pwm_lvl;
  logic       run, skip_n, supply_ok;
  logic       hs_off_fb, ls_off_fb;
  logic       hs_stuck, ls_stuck;
  logic       hs_gate, ls_gate, fb_fault;

  int n_chk  = 0;
  int n_fail = 0;
  int n_ovl  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  buck_gate_seq #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD), .OFF_CYC(OFFC), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .run(run), .skip_n(skip_n),
    .supply_ok(supply_ok), .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fb_fault(fb_fault)
  );

  // gate discharge model: one cycle after the gate drops
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_off_fb <= 1'b1;
      ls_off_fb <= 1'b1;
    end else begin
      hs_off_fb <= hs_stuck ? 1'b0 : !hs_gate;
      ls_off_fb <= ls_stuck ? 1'b0 : !ls_gate;
    end
  end

  always @(negedge clk) if (rst_n && hs_gate && ls_gate) n_ovl++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {hs_gate, ls_gate, fb_fault};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gh/gl/flt=%b expected %b", req, act, exp);
    end
  endtask

  task automatic settle_to(input logic [1:0] lvl);
    pwm_lvl = lvl;
    tick(SETTLE);
  endtask

  task automatic t_reset;
    check("R9 reset", 3'b000);
  endtask

  task automatic t_truth;
    for (int s = 1; s >= 0; s--) begin
      for (int p = 0; p < 3; p++) begin
        logic [2:0] e;
        skip_n = s[0];
        pwm_lvl = (p == 2) ? 2'b10 : 2'(p);
        tick(SETTLE);
        e = (p == 1) ? 3'b100 : ((p == 0 && s == 1) ? 3'b010 : 3'b000);
        check((s == 1) ? "R1 truth row" : "R4 truth row skip", e);
      end
    end
    skip_n = 1'b1;
  endtask

  task automatic t_timing;
    settle_to(2'b01);
    pwm_lvl = 2'b00;
    tick(OFFC);
    check("R2 hs held during off delay", 3'b100);
    tick(1);
    check("R2 hs falls at off edge", 3'b000);
    tick(DEAD);
    check("R2 ls waits dead time", 3'b000);
    tick(1);
    check("R2 ls rises after dead time", 3'b010);
  endtask

  task automatic t_holdoff;
    settle_to(2'b00);
    pwm_lvl = 2'b10;
    tick(HOLD - 1);
    pwm_lvl = 2'b00;
    tick(40);
    check("R7 short mid keeps state", 3'b010);
    pwm_lvl = 2'b11;
    tick(HOLD + OFFC - 1);
    check("R7 gate held before expiry", 3'b010);
    tick(1);
    check("R7 hold-off expiry turns off", 3'b000);
    settle_to(2'b01);
    skip_n = 1'b0;
    pwm_lvl = 2'b10;
    tick(SETTLE);
    check("R7 hold-off with skip low", 3'b000);
    skip_n = 1'b1;
  endtask

  task automatic t_skip;
    settle_to(2'b00);
    skip_n = 1'b0;
    tick(1);
    check("R4 skip blanks ls next edge", 3'b000);
    settle_to(2'b01);
    check("R4 hs follows high under skip", 3'b100);
    skip_n = 1'b1;
  endtask

  task automatic t_race;
    settle_to(2'b01);
    pwm_lvl = 2'b00;
    tick(OFFC + DEAD + 1);
    skip_n = 1'b0;
    tick(1);
    check("R4 skip wins over dead-time end", 3'b000);
    tick(5);
    check("R3 R4 ls stays off", 3'b000);
    skip_n = 1'b1;
  endtask

  task automatic t_disable;
    settle_to(2'b01);
    run = 1'b0;
    tick(1);
    check("R5 run low drops hs", 3'b000);
    pwm_lvl = 2'b00;
    tick(SETTLE);
    check("R5 run low keeps ls off", 3'b000);
    run = 1'b1;
    tick(SETTLE);
    check("R5 resume after run", 3'b010);
  endtask

  task automatic t_uvlo;
    settle_to(2'b00);
    supply_ok = 1'b0;
    tick(1);
    check("R6 undervoltage drops ls", 3'b000);
    pwm_lvl = 2'b01;
    tick(SETTLE);
    check("R6 undervoltage keeps hs off", 3'b000);
    supply_ok = 1'b1;
    tick(SETTLE);
    check("R6 resume after supply", 3'b100);
  endtask

  task automatic t_fault;
    settle_to(2'b00);
    ls_stuck = 1'b1;
    pwm_lvl = 2'b01;
    tick(OFFC + TMO + 10);
    check("R8 timeout raises fault", 3'b001);
    ls_stuck = 1'b0;
    tick(SETTLE);
    check("R8 fault is sticky", 3'b001);
    run = 1'b0;
    tick(1);
    check("R8 run low clears fault", 3'b000);
    run = 1'b1;
    tick(SETTLE);
    check("R8 normal after clear", 3'b100);
  endtask

  initial begin
    rst_n = 1'b0; pwm_lvl = 2'b00; run = 1'b1; skip_n = 1'b1; supply_ok = 1'b1;
    hs_stuck = 1'b0; ls_stuck = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_truth();
    t_timing();
    t_holdoff();
    t_skip();
    t_race();
    t_disable();
    t_uvlo();
    t_fault();
    n_chk++;
    if (n_ovl != 0) begin
      n_fail++;
      $display("FAIL R3 overlap cycles: got %0d expected 0", n_ovl);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule